// File: doc/BRIEF.md
# Single-Lane SPI Serial SRAM Slave

This block is the SPI slave front end of a byte-addressed serial SRAM. It runs from a fast system clock and oversamples the chip-select, serial clock and serial data input through synchronisers. A command starts with an opcode byte, shifted in MSB first. Memory commands then take a 24-bit address in three bytes and move data bytes between the serial line and an internal synchronous byte array. Reads come in two forms: a plain read with no latency, and a fast read that skips one dummy byte. Bursts step the address after each byte and wrap to zero past the top of the array.

Writes are gated in four ways: by an active-low protect pin, by a write-enable latch that instructions set and clear, by two block-protect bits in a small status register, and by a busy input from an external store controller. The busy input is sampled when the address completes. Each committed array write produces a one-cycle `sram_written` pulse, so the store controller knows the array holds data that has not been saved yet. The default array is 2 KB (`AW`=11). Setting `AW`=17 gives 128 KB.

Top module: `sspi_sram_slave`

## Requirements
- R1: The array holds 2^AW bytes. Each address is sent as three bytes, MSB first, and only its low AW bits select a byte. The upper bits are ignored.
- R2: SPI modes 0 and 3 are both accepted. MOSI is sampled on rising SCK edges. MISO changes only after a falling SCK edge or on deselect. Data is MSB first.
- R3: Opcode 0x02 followed by an address starts a write. Every complete data byte after the address is committed to the array with no wait bytes.
- R4: Opcode 0x03 starts a plain read. The first data bit appears on MISO at the falling edge that follows the last address bit.
- R5: Opcode 0x0B starts a fast read. One dummy byte follows the address, and its value is ignored. Data starts after the dummy byte.
- R6: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Opcode 0x05 returns the status byte, repeated for as long as CS stays low. The status byte holds: bit0 busy, bit1 write-enable latch, bits 3:2 block-protect, all other bits 0.
- R7: A data byte is not committed when any of these holds: `wprot_n` is low, the write-enable latch is 0, or the target address is protected.
- R8: When CS rises after a write command (0x02 or 0x01) that received at least one complete data byte, the write-enable latch clears. A partial data byte leaves the latch unchanged.
- R9: In burst reads and writes the address steps by one after each byte. After location 2^AW-1 it wraps to 0.
- R10: `sram_written` pulses for exactly one clock for each committed byte.
- R11: While `store_busy` is high, status bit0 reads 1. If `store_busy` is high when the last address byte completes, the command's writes are dropped and its reads return 0x00.
- R12: Raising CS aborts any command. While CS is high, MISO is 0 and nothing is written. The next select decodes a fresh opcode.
- R13: Opcode 0x01 takes one data byte and copies its bits 3:2 into block-protect, if the latch is set and `wprot_n` is high. The protected area for each block-protect value is: 00 nothing, 01 the top quarter, 10 the top half, 11 the whole array.
- R14: After reset, the latch is 0, block-protect is 00, and MISO and `sram_written` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | SPI serial clock |
| mosi | input | 1 | Serial data from the master |
| wprot_n | input | 1 | Write-protect pin, active low |
| store_busy | input | 1 | Busy flag from the store controller |
| miso | output | 1 | Serial data to the master (registered) |
| sram_written | output | 1 | One-cycle pulse for each committed byte |

## Verification
Some properties are checked on every cycle. Each commit must coincide with a set write-enable latch, a high protect pin, no busy inhibit and an unprotected address. A commit pulse never lasts two cycles. MISO moves only after a falling SCK edge or on deselect. The latch is clear after a deselect that ends a write. Other behaviour can only be shown by the bench's scenarios, each checked against a behavioural memory model: data integrity across bursts and address wrap, zero-latency and dummy-byte read timing, mode 3 framing, aliasing of the upper address bits, and commands aborted mid-address or mid-byte.

// File: rtl/sspi_pkg.sv
package sspi_pkg;
  localparam int ADDR_W     = 24;
  localparam int ADDR_BYTES = 3;

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_FREAD = 8'h0B;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_DUMMY, PH_RDATA, PH_WDATA, PH_STAT, PH_SRW, PH_IDLE
  } phase_e;
endpackage

// File: rtl/sspi_sync.sv
module sspi_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sspi_ram.sv
module sspi_ram #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [7:0]    q
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) q <= mem[ra];
  end
endmodule

// File: rtl/sspi_prot.sv
module sspi_prot #(
  parameter int AW = 11
) (
  input  logic [1:0]    bp,
  input  logic [AW-1:0] addr,
  output logic          locked
);
  always_comb begin
    unique case (bp)
      2'b00:   locked = 1'b0;
      2'b01:   locked = (addr[AW-1:AW-2] == 2'b11);
      2'b10:   locked = addr[AW-1];
      default: locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/sspi_sram_slave.sv
module sspi_sram_slave
  import sspi_pkg::*;
#(
  parameter int AW   = 11,
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic wprot_n,
  input  logic store_busy,
  output logic miso,
  output logic sram_written
);
  localparam int AB_W = $clog2(ADDR_BYTES);
  localparam logic [AB_W-1:0] LAST_AB = AB_W'(ADDR_BYTES - 1);

  logic [2:0] sync_q;
  logic       cs_s, sck_s, mosi_s, sck_d;
  logic       sck_rise, sck_fall, byte_done;

  phase_e            phase_q;
  logic [2:0]        bitcnt_q;
  logic [7:0]        rx_q, tx_q, rx_next;
  logic              ld_pend_q;
  logic [AB_W-1:0]   abyte_q;
  logic [ADDR_W-1:0] addr_q, addr_inc;
  logic              fast_q, is_wr_q, wel_q, wr_done_q, inhibit_q, src_stat_q;
  logic [1:0]        bp_q;
  logic              rd_req_q, we_q, miso_q;
  logic [AW-1:0]     wa_q;
  logic [7:0]        wd_q, ram_q, status, out_byte;
  logic              locked;

  sspi_sync #(.W(3), .STAGES(SYNC), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sck, mosi}), .q(sync_q)
  );
  assign cs_s   = sync_q[2];
  assign sck_s  = sync_q[1];
  assign mosi_s = sync_q[0];

  sspi_ram #(.AW(AW)) u_ram (
    .clk(clk), .we(we_q), .wa(wa_q), .wd(wd_q),
    .re(rd_req_q), .ra(addr_q[AW-1:0]), .q(ram_q)
  );

  sspi_prot #(.AW(AW)) u_prot (
    .bp(bp_q), .addr(addr_q[AW-1:0]), .locked(locked)
  );

  assign sck_rise  = sck_s & ~sck_d & ~cs_s;
  assign sck_fall  = ~sck_s & sck_d & ~cs_s;
  assign byte_done = sck_rise && (bitcnt_q == 3'd7);
  assign rx_next   = {rx_q[6:0], mosi_s};
  assign addr_inc  = {addr_q[ADDR_W-1:AW], addr_q[AW-1:0] + AW'(1)};
  assign status    = {4'b0000, bp_q, wel_q, store_busy};
  assign out_byte  = src_stat_q ? status : (inhibit_q ? 8'h00 : ram_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d      <= 1'b0;
      phase_q    <= PH_OPC;
      bitcnt_q   <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      ld_pend_q  <= 1'b0;
      abyte_q    <= '0;
      addr_q     <= '0;
      fast_q     <= 1'b0;
      is_wr_q    <= 1'b0;
      wel_q      <= 1'b0;
      wr_done_q  <= 1'b0;
      inhibit_q  <= 1'b0;
      src_stat_q <= 1'b0;
      bp_q       <= 2'b00;
      rd_req_q   <= 1'b0;
      we_q       <= 1'b0;
      wa_q       <= '0;
      wd_q       <= '0;
      miso_q     <= 1'b0;
    end else begin
      sck_d    <= sck_s;
      rd_req_q <= 1'b0;
      we_q     <= 1'b0;
      if (cs_s) begin
        phase_q    <= PH_OPC;
        bitcnt_q   <= '0;
        rx_q       <= '0;
        tx_q       <= '0;
        ld_pend_q  <= 1'b0;
        abyte_q    <= '0;
        inhibit_q  <= 1'b0;
        src_stat_q <= 1'b0;
        miso_q     <= 1'b0;
        wr_done_q  <= 1'b0;
        if (wr_done_q) wel_q <= 1'b0;
      end else begin
        if (sck_rise) begin
          rx_q     <= rx_next;
          bitcnt_q <= bitcnt_q + 3'd1;
        end
        if (byte_done) begin
          unique case (phase_q)
            PH_OPC: begin
              unique case (rx_next)
                OP_READ:  begin phase_q <= PH_ADDR; fast_q <= 1'b0; is_wr_q <= 1'b0; end
                OP_FREAD: begin phase_q <= PH_ADDR; fast_q <= 1'b1; is_wr_q <= 1'b0; end
                OP_WRITE: begin phase_q <= PH_ADDR; fast_q <= 1'b0; is_wr_q <= 1'b1; end
                OP_WREN:  begin wel_q <= 1'b1; phase_q <= PH_IDLE; end
                OP_WRDI:  begin wel_q <= 1'b0; phase_q <= PH_IDLE; end
                OP_RDSR:  begin phase_q <= PH_STAT; src_stat_q <= 1'b1; ld_pend_q <= 1'b1; end
                OP_WRSR:  phase_q <= PH_SRW;
                default:  phase_q <= PH_IDLE;
              endcase
            end
            PH_ADDR: begin
              addr_q  <= {addr_q[ADDR_W-9:0], rx_next};
              abyte_q <= abyte_q + AB_W'(1);
              if (abyte_q == LAST_AB) begin
                inhibit_q <= store_busy;
                if (is_wr_q)     phase_q <= PH_WDATA;
                else if (fast_q) phase_q <= PH_DUMMY;
                else begin
                  phase_q   <= PH_RDATA;
                  rd_req_q  <= 1'b1;
                  ld_pend_q <= 1'b1;
                end
              end
            end
            PH_DUMMY: begin
              phase_q   <= PH_RDATA;
              rd_req_q  <= 1'b1;
              ld_pend_q <= 1'b1;
            end
            PH_RDATA: begin
              addr_q    <= addr_inc;
              rd_req_q  <= 1'b1;
              ld_pend_q <= 1'b1;
            end
            PH_WDATA: begin
              if (!locked && wel_q && wprot_n && !inhibit_q) begin
                we_q <= 1'b1;
                wa_q <= addr_q[AW-1:0];
                wd_q <= rx_next;
              end
              addr_q    <= addr_inc;
              wr_done_q <= 1'b1;
            end
            PH_STAT: ld_pend_q <= 1'b1;
            PH_SRW: begin
              if (wel_q && wprot_n) bp_q <= rx_next[3:2];
              wr_done_q <= 1'b1;
              phase_q   <= PH_IDLE;
            end
            default: ;
          endcase
        end
        if (sck_fall) begin
          if (ld_pend_q) begin
            miso_q    <= out_byte[7];
            tx_q      <= {out_byte[6:0], 1'b0};
            ld_pend_q <= 1'b0;
          end else begin
            miso_q <= tx_q[7];
            tx_q   <= {tx_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign miso         = miso_q;
  assign sram_written = we_q;
endmodule

// File: rtl/sspi_sram_slave_chk.sv
module sspi_sram_slave_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          miso,
  input logic          sram_written,
  input logic          cs_s,
  input logic          sck_fall,
  input logic          wel,
  input logic          wr_done,
  input logic          inhibit,
  input logic [1:0]    bp,
  input logic [AW-1:0] waddr,
  input logic          wprot_n
);
  AST_WR_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    sram_written |=> !sram_written); // R10

  AST_WR_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    sram_written |-> ($past(wel) && $past(wprot_n))); // R7

  AST_WR_NOT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    sram_written |-> ((bp == 2'b00) ||
                      (bp == 2'b01 && waddr[AW-1:AW-2] != 2'b11) ||
                      (bp == 2'b10 && !waddr[AW-1]))); // R13

  AST_WR_NOT_INHIBITED: assert property (@(posedge clk) disable iff (rst)
    sram_written |-> !$past(inhibit)); // R11

  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(miso) |-> ($past(sck_fall) || $past(cs_s))); // R2

  AST_WEL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_s) && $past(wr_done)) |-> !wel); // R8
endmodule

bind sspi_sram_slave sspi_sram_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .miso(miso), .sram_written(sram_written),
  .cs_s(cs_s), .sck_fall(sck_fall), .wel(wel_q), .wr_done(wr_done_q),
  .inhibit(inhibit_q), .bp(bp_q), .waddr(wa_q), .wprot_n(wprot_n)
);

// File: tb/sspi_sram_slave_tb.sv
module sspi_sram_slave_tb;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wprot_n = 1'b1, store_busy = 1'b0;
  logic miso, sram_written;

  int checks = 0, errors = 0, pulses = 0, exp_pulse = 0, idle_cnt = 0;
  bit finished = 0, m3 = 0;
  logic [7:0] mem_m [DEPTH];
  bit         known_m [DEPTH];
  bit         wel_m = 0;
  logic [1:0] bp_m = 2'b00;

  always #4 clk = ~clk;

  sspi_sram_slave #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wprot_n(wprot_n), .store_busy(store_busy), .miso(miso), .sram_written(sram_written)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (!rst && sram_written === 1'b1) pulses++;

  // per-clock comparison while deselected: R12
  always @(negedge clk) begin
    if (rst || !cs_n) idle_cnt <= 0;
    else begin
      idle_cnt <= idle_cnt + 1;
      if (idle_cnt > 4) chk(miso === 1'b0 && sram_written === 1'b0, "R12 idle outputs",
                            {miso, sram_written}, 0);
    end
  end

  function automatic bit locked_m(input int a);
    case (bp_m)
      2'b00:   return 0;
      2'b01:   return a >= (DEPTH * 3) / 4;
      2'b10:   return a >= DEPTH / 2;
      default: return 1;
    endcase
  endfunction

  task automatic sbit(input logic b, output logic r);
    @(negedge clk) sck = 1'b0; mosi = b;
    repeat (8) @(negedge clk);
    r = miso; sck = 1'b1;
    repeat (7) @(negedge clk);
  endtask

  task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) sbit(t[i], r[i]);
  endtask

  task automatic cs_on();
    @(negedge clk) sck = m3;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_off();
    @(negedge clk) if (!m3) sck = 1'b0;
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] r;
    xbyte(a[23:16], r); xbyte(a[15:8], r); xbyte(a[7:0], r);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    cs_on(); xbyte(op, r); cs_off();
    if (op == 8'h06) wel_m = 1;
    if (op == 8'h04) wel_m = 0;
  endtask

  task automatic wr_cmd(input logic [23:0] a, input int n, input logic [7:0] base, input string req);
    logic [7:0] r;
    int ai;
    cs_on(); xbyte(8'h02, r); send_addr(a);
    for (int i = 0; i < n; i++) begin
      ai = (int'(a[AW-1:0]) + i) % DEPTH;
      xbyte(base + 8'(i), r);
      if (wel_m && wprot_n && !store_busy && !locked_m(ai)) begin
        mem_m[ai] = base + 8'(i); known_m[ai] = 1; exp_pulse++;
      end
    end
    cs_off();
    if (n > 0) wel_m = 0;
    chk(pulses == exp_pulse, {req, " R10 pulse count"}, pulses, exp_pulse);
  endtask

  task automatic rd_cmd(input logic [23:0] a, input int n, input bit fast, input string req);
    logic [7:0] r;
    int ai;
    cs_on(); xbyte(fast ? 8'h0B : 8'h03, r); send_addr(a);
    if (fast) xbyte(8'hA5, r);
    for (int i = 0; i < n; i++) begin
      ai = (int'(a[AW-1:0]) + i) % DEPTH;
      xbyte(8'h00, r);
      if (store_busy) chk(r === 8'h00, {req, " R11 busy read"}, r, 0);
      else if (known_m[ai]) chk(r === mem_m[ai], req, r, mem_m[ai]);
    end
    cs_off();
  endtask

  task automatic rdsr(input int n, input string req);
    logic [7:0] r, e;
    cs_on(); xbyte(8'h05, r);
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00, r);
      e = {4'b0000, bp_m, wel_m, store_busy};
      chk(r === e, req, r, e);
    end
    cs_off();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    cs_on(); xbyte(8'h01, r); xbyte(v, r); cs_off();
    if (wel_m && wprot_n) bp_m = v[3:2];
    wel_m = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic       rb;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(miso === 1'b0 && sram_written === 1'b0, "R14 reset outputs", {miso, sram_written}, 0);
    rdsr(2, "R14 reset status");

    cmd1(8'h06); rdsr(1, "R6 WEL set");
    cmd1(8'h04); rdsr(1, "R6 WEL cleared");

    cmd1(8'h06); wr_cmd(24'h000010, 4, 8'hA0, "R3 burst write");
    rdsr(1, "R8 WEL clear after write");
    rd_cmd(24'h000010, 4, 0, "R4 plain read");
    rd_cmd(24'h000011, 3, 1, "R5 fast read");
    rd_cmd(24'hFF0010, 2, 0, "R1 upper bits ignored");

    m3 = 1;
    cmd1(8'h06); wr_cmd(24'(DEPTH - 2), 4, 8'h50, "R9 wrap write mode3");
    rd_cmd(24'(DEPTH - 1), 3, 0, "R9 R2 wrap read mode3");
    rdsr(2, "R2 R6 status mode3");
    m3 = 0;
    @(negedge clk) sck = 1'b0;

    cmd1(8'h06); wr_cmd(24'h000020, 2, 8'h30, "R3 setup");
    wr_cmd(24'h000020, 2, 8'h77, "R7 no WEL");
    rd_cmd(24'h000020, 2, 0, "R7 data kept no WEL");
    wprot_n = 1'b0;
    cmd1(8'h06); wr_cmd(24'h000020, 1, 8'h99, "R7 pin protect");
    wprot_n = 1'b1;
    rd_cmd(24'h000020, 1, 0, "R7 data kept pin");

    cmd1(8'h06); wrsr(8'h04); rdsr(1, "R13 BP top quarter");
    cmd1(8'h06); wr_cmd(24'(DEPTH - 2), 1, 8'hEE, "R13 locked write");
    rd_cmd(24'(DEPTH - 2), 1, 0, "R13 locked data kept");
    cmd1(8'h06); wr_cmd(24'(DEPTH / 2), 1, 8'h42, "R13 unlocked write");
    rd_cmd(24'(DEPTH / 2), 1, 0, "R13 unlocked data");
    cmd1(8'h06); wrsr(8'h08); rdsr(1, "R13 BP top half");
    cmd1(8'h06); wr_cmd(24'(DEPTH / 2), 1, 8'h43, "R13 half locked");
    rd_cmd(24'(DEPTH / 2), 1, 0, "R13 half data kept");
    cmd1(8'h06); wrsr(8'h00); rdsr(1, "R13 BP cleared");

    store_busy = 1'b1;
    rdsr(1, "R11 WIP set");
    cmd1(8'h06); wr_cmd(24'h000010, 2, 8'h11, "R11 busy write");
    rd_cmd(24'h000010, 2, 0, "R11 busy read");
    store_busy = 1'b0;
    rd_cmd(24'h000010, 2, 0, "R11 data kept busy");

    cmd1(8'h06);
    cs_on(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h00, r); cs_off();
    rdsr(1, "R12 abort mid address");
    cs_on(); xbyte(8'h02, r); send_addr(24'h000010);
    for (int i = 0; i < 4; i++) sbit(1'b1, rb);
    cs_off();
    chk(pulses == exp_pulse, "R8 R12 partial byte no write", pulses, exp_pulse);
    rdsr(1, "R8 partial byte keeps WEL");
    rd_cmd(24'h000010, 4, 0, "R12 data after abort");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule